// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Control

This block steers a five-stage in-order pipeline around its two unavoidable hazards. The first is a load whose result is needed by the very next instruction as an ALU operand. The second is a conditional branch that was fetched past on a not-taken guess and then turned out to be taken. A load-use pair freezes the program counter and the fetch/decode register for one cycle and slips a bubble into the decode/execute register. A taken branch sends the PC to the branch target and discards the wrong-path work in flight.

The branch is resolved one stage late, in the memory stage, from the zero flag latched beside it in the execute/memory register. The block carries a compact model of the three pipeline registers. The model holds only the control word, the destination and the source fields of each instruction, so stall and flush sequences can be observed at the ports. The datapath is not part of the block.

A store whose only link to a preceding load is its data operand does not stall. The loaded value reaches it through memory-stage forwarding. Producers further ahead never stall either, because the register file writes on the falling edge.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: The control word has bit0 = register write, bit1 = memory read, bit2 = memory write, bit3 = memory-to-register and bit4 = branch. A stall is raised in the same cycle when the decode/execute slot has bit1 set and a nonzero destination that equals a source used by the decode-stage instruction. Such a source is the first source, or the second source of any non-store. A stall drives `pc_write` = 0, `ifid_write` = 0 and `bubble_sel` = 1.
- R2: When a store (bit2 set) depends on the load only through its second source, the store data, no stall is raised.
- R3: A load whose destination is register 0 never causes a stall.
- R4: Only a load in the decode/execute slot stalls. A non-load producer, or a load already in the execute/memory slot, causes no stall.
- R5: A stall lasts one cycle. At the next edge the decode/execute slot takes a bubble (control 0, destination 0), while the decode-stage instruction is held and issues on the following edge.
- R6: A branch is taken when the execute/memory slot has bit4 set and its latched zero flag is 1. In that cycle `redirect` = 1 and `pc_write` = 1.
- R7: After a taken branch, the fetch/decode, decode/execute and execute/memory slots all hold bubbles for one cycle. The instruction at the target reaches decode on the edge after that.
- R8: When a taken branch and a load-use hazard fall in the same cycle, the flush wins: `bubble_sel` = 0 and `pc_write` = 1.
- R9: A branch whose latched zero flag is 0 causes no redirect, and the younger instructions proceed unchanged.
- R10: While reset is held, every slot is a bubble, `pc_write` = 1 and `redirect` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_ctrl | input | 5 | Control word of the instruction being fetched |
| if_rd | input | REG_AW | Destination of the fetched instruction |
| if_rs1 | input | REG_AW | First source of the fetched instruction |
| if_rs2 | input | REG_AW | Second source of the fetched instruction |
| if_use_rs1 | input | 1 | Fetched instruction reads its first source |
| if_use_rs2 | input | 1 | Fetched instruction reads its second source |
| ex_zero | input | 1 | ALU zero flag of the instruction in execute |
| pc_write | output | 1 | PC may advance or load a target |
| ifid_write | output | 1 | Fetch/decode register may load |
| bubble_sel | output | 1 | Zero the control entering decode/execute |
| redirect | output | 1 | PC loads the branch target |
| id_ctrl | output | 5 | Control word held in fetch/decode |
| id_rd | output | REG_AW | Destination held in fetch/decode |
| idex_ctrl | output | 5 | Control word held in decode/execute |
| idex_rd | output | REG_AW | Destination held in decode/execute |
| exmem_ctrl | output | 5 | Control word held in execute/memory |

## Verification
The bench builds the block with its default parameters: a 5-bit register address and the store-data exemption enabled. With these defaults it can reach the exemption, register 0 as a load destination, and back-to-back load chains. Short programs run from reset against a fixed branch-zero setting. The scoreboard compares the stall, redirect and slot contents cycle by cycle. These programs also cover a taken branch that meets a load-use pair in the same cycle.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic branch;
    logic mem_to_reg;
    logic mem_write;
    logic mem_read;
    logic reg_write;
  } ctrl_t;

  localparam ctrl_t CTRL_BUBBLE = '0;
endpackage

// File: rtl/hzd_loaduse.sv
`timescale 1ns/1ps
module hzd_loaduse #(
  parameter int REG_AW = 5,
  parameter bit STORE_DATA_FWD = 1'b1
) (
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic              id_is_store,
  output logic              hazard
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  function automatic logic src_hit(input logic used,
                                   input logic [REG_AW-1:0] src,
                                   input logic [REG_AW-1:0] dst);
    return used && (src == dst);
  endfunction

  logic rs2_counts;

  generate
    if (STORE_DATA_FWD) begin : g_store_exempt
      // store data is served by memory-stage forwarding
      assign rs2_counts = id_use_rs2 && !id_is_store;
    end else begin : g_no_exempt
      assign rs2_counts = id_use_rs2;
    end
  endgenerate

  always_comb begin
    hazard = ex_mem_read && (ex_rd != ZERO_REG) &&
             (src_hit(id_use_rs1, id_rs1, ex_rd) ||
              src_hit(rs2_counts, id_rs2, ex_rd));
  end
endmodule

// File: rtl/hzd_branch_res.sv
`timescale 1ns/1ps
module hzd_branch_res (
  input  logic mem_branch,
  input  logic mem_zero,
  input  logic hazard,
  output logic taken,
  output logic stall,
  output logic pc_write,
  output logic ifid_write
);
  always_comb begin
    taken      = mem_branch && mem_zero;
    // a flush discards the dependent instruction, so it outranks the stall
    stall      = hazard && !taken;
    pc_write   = !stall;
    ifid_write = !stall;
  end
endmodule

// File: rtl/hzd_stage_regs.sv
`timescale 1ns/1ps
module hzd_stage_regs
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             if_ctrl,
  input  logic [REG_AW-1:0] if_rd,
  input  logic [REG_AW-1:0] if_rs1,
  input  logic [REG_AW-1:0] if_rs2,
  input  logic              if_use_rs1,
  input  logic              if_use_rs2,
  input  logic              ex_zero,
  input  logic              ifid_write,
  input  logic              bubble_sel,
  input  logic              flush,
  output ctrl_t             id_ctrl,
  output logic [REG_AW-1:0] id_rd,
  output logic [REG_AW-1:0] id_rs1,
  output logic [REG_AW-1:0] id_rs2,
  output logic              id_use_rs1,
  output logic              id_use_rs2,
  output ctrl_t             idex_ctrl,
  output logic [REG_AW-1:0] idex_rd,
  output ctrl_t             exmem_ctrl,
  output logic              exmem_zero
);
  typedef struct packed {
    ctrl_t             ctrl;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic              use1;
    logic              use2;
  } fd_slot_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [REG_AW-1:0] rd;
  } dx_slot_t;

  fd_slot_t fd_q, fd_in;
  dx_slot_t dx_q;

  assign fd_in = '{ctrl: if_ctrl, rd: if_rd, rs1: if_rs1, rs2: if_rs2,
                   use1: if_use_rs1, use2: if_use_rs2};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fd_q       <= '0;
      dx_q       <= '0;
      exmem_ctrl <= CTRL_BUBBLE;
      exmem_zero <= 1'b0;
    end else begin
      if (flush)           fd_q <= '0;
      else if (ifid_write) fd_q <= fd_in;

      if (flush || bubble_sel) dx_q <= '0;
      else                     dx_q <= '{ctrl: fd_q.ctrl, rd: fd_q.rd};

      if (flush) begin
        exmem_ctrl <= CTRL_BUBBLE;
        exmem_zero <= 1'b0;
      end else begin
        exmem_ctrl <= dx_q.ctrl;
        exmem_zero <= ex_zero;
      end
    end
  end

  assign id_ctrl    = fd_q.ctrl;
  assign id_rd      = fd_q.rd;
  assign id_rs1     = fd_q.rs1;
  assign id_rs2     = fd_q.rs2;
  assign id_use_rs1 = fd_q.use1;
  assign id_use_rs2 = fd_q.use2;
  assign idex_ctrl  = dx_q.ctrl;
  assign idex_rd    = dx_q.rd;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter bit STORE_DATA_FWD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] if_ctrl,
  input  logic [REG_AW-1:0] if_rd,
  input  logic [REG_AW-1:0] if_rs1,
  input  logic [REG_AW-1:0] if_rs2,
  input  logic              if_use_rs1,
  input  logic              if_use_rs2,
  input  logic              ex_zero,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              bubble_sel,
  output logic              redirect,
  output logic [CTRL_W-1:0] id_ctrl,
  output logic [REG_AW-1:0] id_rd,
  output logic [CTRL_W-1:0] idex_ctrl,
  output logic [REG_AW-1:0] idex_rd,
  output logic [CTRL_W-1:0] exmem_ctrl
);
  ctrl_t             id_c, dx_c, xm_c;
  logic [REG_AW-1:0] id_rs1, id_rs2;
  logic              id_use_rs1, id_use_rs2;
  logic              xm_zero;
  logic              hazard;   // raw load-use detection
  logic              taken;    // branch resolved taken in memory stage

  hzd_stage_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .if_ctrl(ctrl_t'(if_ctrl)), .if_rd(if_rd), .if_rs1(if_rs1), .if_rs2(if_rs2),
    .if_use_rs1(if_use_rs1), .if_use_rs2(if_use_rs2), .ex_zero(ex_zero),
    .ifid_write(ifid_write), .bubble_sel(bubble_sel), .flush(taken),
    .id_ctrl(id_c), .id_rd(id_rd), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .idex_ctrl(dx_c), .idex_rd(idex_rd),
    .exmem_ctrl(xm_c), .exmem_zero(xm_zero)
  );

  hzd_loaduse #(.REG_AW(REG_AW), .STORE_DATA_FWD(STORE_DATA_FWD)) u_lu (
    .ex_mem_read(dx_c.mem_read), .ex_rd(idex_rd),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_store(id_c.mem_write), .hazard(hazard)
  );

  hzd_branch_res u_br (
    .mem_branch(xm_c.branch), .mem_zero(xm_zero), .hazard(hazard),
    .taken(taken), .stall(bubble_sel),
    .pc_write(pc_write), .ifid_write(ifid_write)
  );

  assign redirect   = taken;
  assign id_ctrl    = id_c;
  assign idex_ctrl  = dx_c;
  assign exmem_ctrl = xm_c;
endmodule

// File: rtl/hzd_checker.sv
`timescale 1ns/1ps
module hzd_checker #(
  parameter int REG_AW = 5,
  parameter int CTRL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hazard,
  input logic              pc_write,
  input logic              ifid_write,
  input logic              bubble_sel,
  input logic              redirect,
  input logic [CTRL_W-1:0] id_ctrl,
  input logic [REG_AW-1:0] id_rd,
  input logic [CTRL_W-1:0] idex_ctrl,
  input logic [REG_AW-1:0] idex_rd,
  input logic [CTRL_W-1:0] exmem_ctrl
);
  a_r1_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hazard && !redirect) |-> (!pc_write && !ifid_write && bubble_sel));

  a_r3_no_x0_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rd == '0) |-> !bubble_sel);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> !bubble_sel);

  a_r5_bubble_in: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> (idex_ctrl == '0 && idex_rd == '0));

  a_r5_decode_held: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> ($stable(id_ctrl) && $stable(id_rd)));

  a_r6_redirect_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (exmem_ctrl[4] && pc_write));

  a_r7_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (id_ctrl == '0 && idex_ctrl == '0 && exmem_ctrl == '0));

  a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !bubble_sel);
endmodule

bind pipe_hazard_ctrl hzd_checker #(.REG_AW(REG_AW), .CTRL_W(hzd_pkg::CTRL_W)) u_hzd_chk (
  .clk(clk), .rst_n(rst_n), .hazard(hazard), .pc_write(pc_write),
  .ifid_write(ifid_write), .bubble_sel(bubble_sel), .redirect(redirect),
  .id_ctrl(id_ctrl), .id_rd(id_rd), .idex_ctrl(idex_ctrl), .idex_rd(idex_rd),
  .exmem_ctrl(exmem_ctrl)
);

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb_top;
  localparam int AW = 5;
  localparam logic [4:0] C_LD  = 5'b01011;
  localparam logic [4:0] C_ALU = 5'b00001;
  localparam logic [4:0] C_SD  = 5'b00100;
  localparam logic [4:0] C_BEQ = 5'b10000;

  typedef enum int {F_STALL, F_PCW, F_IFW, F_REDIR, F_IDCTRL, F_IDRD,
                    F_IDEXCTRL, F_IDEXRD, F_EXMEMCTRL} field_e;

  typedef struct {
    int     cyc;
    field_e fld;
    int     exp;
    string  req;
  } item_t;

  typedef struct packed {
    logic [4:0]    ctrl;
    logic [AW-1:0] rd;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          u1;
    logic          u2;
  } inst_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]    if_ctrl = '0;
  logic [AW-1:0] if_rd = '0, if_rs1 = '0, if_rs2 = '0;
  logic          if_use_rs1 = 1'b0, if_use_rs2 = 1'b0, ex_zero = 1'b0;
  logic          pc_write, ifid_write, bubble_sel, redirect;
  logic [4:0]    id_ctrl, idex_ctrl, exmem_ctrl;
  logic [AW-1:0] id_rd, idex_rd;

  always #4 clk = ~clk;

  pipe_hazard_ctrl #(.REG_AW(AW), .STORE_DATA_FWD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .if_ctrl(if_ctrl), .if_rd(if_rd),
    .if_rs1(if_rs1), .if_rs2(if_rs2), .if_use_rs1(if_use_rs1),
    .if_use_rs2(if_use_rs2), .ex_zero(ex_zero), .pc_write(pc_write),
    .ifid_write(ifid_write), .bubble_sel(bubble_sel), .redirect(redirect),
    .id_ctrl(id_ctrl), .id_rd(id_rd), .idex_ctrl(idex_ctrl),
    .idex_rd(idex_rd), .exmem_ctrl(exmem_ctrl)
  );

  int    checks = 0, failures = 0;
  item_t sb_q[$];
  inst_t prog[16];
  int    target = 0;
  int    pc_next = 0;
  int    cyc = 0;
  bit    running = 1'b0;
  int    wd = 0;

  function automatic inst_t mk(logic [4:0] c, int rd, int s1, int s2, bit u1, bit u2);
    inst_t t;
    t.ctrl = c; t.rd = AW'(rd); t.rs1 = AW'(s1); t.rs2 = AW'(s2); t.u1 = u1; t.u2 = u2;
    return t;
  endfunction

  task automatic drive_fetch(int pc);
    inst_t t;
    t = (pc < 16) ? prog[pc] : '0;
    if_ctrl = t.ctrl; if_rd = t.rd; if_rs1 = t.rs1; if_rs2 = t.rs2;
    if_use_rs1 = t.u1; if_use_rs2 = t.u2;
  endtask

  task automatic expect_at(int c, field_e f, int v, string r);
    item_t it;
    it.cyc = c; it.fld = f; it.exp = v; it.req = r;
    sb_q.push_back(it);
  endtask

  function automatic int observe(field_e f);
    case (f)
      F_STALL:     return int'(bubble_sel);
      F_PCW:       return int'(pc_write);
      F_IFW:       return int'(ifid_write);
      F_REDIR:     return int'(redirect);
      F_IDCTRL:    return int'(id_ctrl);
      F_IDRD:      return int'(id_rd);
      F_IDEXCTRL:  return int'(idex_ctrl);
      F_IDEXRD:    return int'(idex_rd);
      default:     return int'(exmem_ctrl);
    endcase
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: samples mid-cycle, models the PC, feeds fetch
  always @(negedge clk) begin
    if (running) begin
      int pc_cur;
      cyc++;
      pc_cur = pc_next;
      drive_fetch(pc_cur);
      while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (observe(it.fld) != it.exp) begin
          failures++;
          $display("FAIL %s cyc=%0d field=%s actual=%0d expected=%0d",
                   it.req, cyc, it.fld.name(), observe(it.fld), it.exp);
        end
      end
      if (redirect)      pc_next = target;
      else if (pc_write) pc_next = pc_cur + 1;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_prog(bit z);
    for (int i = 0; i < 16; i++) prog[i] = '0;
    ex_zero = z;
    target = 10;
  endtask

  task automatic run_test(int ncyc);
    @(negedge clk); #1;
    running = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 pc_write", int'(pc_write), 1);
    chk("R10 redirect", int'(redirect), 0);
    chk("R10 slots", int'(id_ctrl) + int'(idex_ctrl) + int'(exmem_ctrl), 0);
    cyc = 0;
    pc_next = 1;
    drive_fetch(0);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (ncyc) @(negedge clk);
    #1;
    running = 1'b0;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++; failures++;
      $display("FAIL %s cyc=%0d never sampled actual=none expected=%0d", it.req, it.cyc, it.exp);
    end
  endtask

  initial begin
    // A: load then ALU reading it as first source
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[1] = mk(C_ALU, 3, 1, 4, 1, 1);
    prog[2] = mk(C_ALU, 5, 6, 7, 1, 1);
    expect_at(1, F_STALL, 0, "R1 no early stall");
    expect_at(2, F_STALL, 1, "R1 stall rs1");
    expect_at(2, F_PCW, 0, "R1 pc frozen");
    expect_at(2, F_IFW, 0, "R1 ifid frozen");
    expect_at(3, F_STALL, 0, "R5 single cycle");
    expect_at(3, F_IDEXCTRL, 0, "R5 bubble ctrl");
    expect_at(3, F_IDEXRD, 0, "R5 bubble rd");
    expect_at(3, F_IDRD, 3, "R5 decode held");
    expect_at(4, F_IDEXRD, 3, "R5 issue after stall");
    expect_at(4, F_IDRD, 5, "R5 next fetched");
    run_test(8);

    // B: second source of ALU
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[1] = mk(C_ALU, 3, 9, 1, 1, 1);
    expect_at(2, F_STALL, 1, "R1 stall rs2");
    run_test(6);

    // C: store data only
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[1] = mk(C_SD, 0, 2, 1, 1, 1);
    expect_at(2, F_STALL, 0, "R2 store data exempt");
    expect_at(3, F_IDEXCTRL, int'(C_SD), "R2 store issues");
    run_test(6);

    // D: store base
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[1] = mk(C_SD, 0, 1, 5, 1, 1);
    expect_at(2, F_STALL, 1, "R1 store base");
    run_test(6);

    // E: branch operand
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[1] = mk(C_BEQ, 0, 1, 3, 1, 1);
    expect_at(2, F_STALL, 1, "R1 branch operand");
    run_test(8);

    // F: load to x0
    clear_prog(0);
    prog[0] = mk(C_LD, 0, 2, 0, 1, 0);
    prog[1] = mk(C_ALU, 3, 0, 0, 1, 1);
    expect_at(2, F_STALL, 0, "R3 x0 no stall");
    run_test(6);

    // G: load two ahead
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[2] = mk(C_ALU, 3, 1, 4, 1, 1);
    expect_at(2, F_STALL, 0, "R4 nop between");
    expect_at(3, F_STALL, 0, "R4 load in mem");
    expect_at(3, F_EXMEMCTRL, int'(C_LD), "R4 load reached mem");
    expect_at(3, F_IDRD, 3, "R4 consumer in decode");
    run_test(6);

    // H: non-load producer
    clear_prog(0);
    prog[0] = mk(C_ALU, 1, 2, 3, 1, 1);
    prog[1] = mk(C_ALU, 3, 1, 1, 1, 1);
    expect_at(2, F_STALL, 0, "R4 alu producer");
    run_test(6);

    // I: taken branch
    clear_prog(1);
    prog[0]  = mk(C_BEQ, 0, 1, 2, 1, 1);
    prog[1]  = mk(C_ALU, 11, 0, 0, 0, 0);
    prog[2]  = mk(C_ALU, 12, 0, 0, 0, 0);
    prog[3]  = mk(C_ALU, 13, 0, 0, 0, 0);
    prog[10] = mk(C_ALU, 20, 0, 0, 0, 0);
    expect_at(2, F_REDIR, 0, "R6 not yet resolved");
    expect_at(3, F_REDIR, 1, "R6 redirect");
    expect_at(3, F_PCW, 1, "R6 pc loads");
    expect_at(4, F_IDCTRL, 0, "R7 ifid flushed");
    expect_at(4, F_IDEXCTRL, 0, "R7 idex flushed");
    expect_at(4, F_EXMEMCTRL, 0, "R7 exmem flushed");
    expect_at(4, F_REDIR, 0, "R7 one redirect");
    expect_at(5, F_IDRD, 20, "R7 target decoded");
    expect_at(6, F_IDEXRD, 20, "R7 target issues");
    run_test(8);

    // J: flush and stall together
    clear_prog(1);
    prog[0]  = mk(C_BEQ, 0, 1, 2, 1, 1);
    prog[1]  = mk(C_LD, 1, 2, 0, 1, 0);
    prog[2]  = mk(C_ALU, 3, 1, 4, 1, 1);
    prog[10] = mk(C_ALU, 20, 0, 0, 0, 0);
    expect_at(3, F_REDIR, 1, "R8 redirect");
    expect_at(3, F_STALL, 0, "R8 stall suppressed");
    expect_at(3, F_PCW, 1, "R8 pc moves");
    expect_at(5, F_IDRD, 20, "R8 target decoded");
    run_test(8);

    // K: not-taken branch
    clear_prog(0);
    prog[0] = mk(C_BEQ, 0, 1, 2, 1, 1);
    prog[1] = mk(C_ALU, 11, 0, 0, 0, 0);
    prog[2] = mk(C_ALU, 12, 0, 0, 0, 0);
    expect_at(3, F_REDIR, 0, "R9 no redirect");
    expect_at(4, F_EXMEMCTRL, int'(C_ALU), "R9 younger continues");
    expect_at(4, F_IDEXRD, 12, "R9 next in order");
    run_test(8);

    // M: chained loads
    clear_prog(0);
    prog[0] = mk(C_LD, 1, 2, 0, 1, 0);
    prog[1] = mk(C_LD, 3, 1, 0, 1, 0);
    prog[2] = mk(C_ALU, 5, 6, 3, 1, 1);
    expect_at(2, F_STALL, 1, "R1 chain first");
    expect_at(3, F_STALL, 0, "R5 chain gap");
    expect_at(4, F_STALL, 1, "R1 chain second");
    expect_at(5, F_STALL, 0, "R5 chain gap two");
    expect_at(6, F_IDEXRD, 5, "R5 chain issue");
    run_test(8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule